// File: doc/BRIEF.md
# Glitch-Free Bank Clock Output Gate

This block sits between a phase-skew clock generator and the clock output pins. It takes eight generated clocks, grouped as four banks of two, and stops or restarts them without producing runt pulses. An active-high stop request first passes through a synchronizer into the timebase domain. Once it is high, every bank except the second one is parked. The second bank keeps running so that it can close an external feedback loop. Outputs run only from a sampled source level, so each output is a one-cycle-delayed copy of its source while it is enabled.

A bank only leaves or rejoins the running state while its source sits at the bank's parked level. Stopping therefore never cuts a pulse short, and restarting always begins with a whole pulse. The fourth bank can be configured as inverted (bank code high/high). It then parks high when the edge-select level is mid or high, and low when that level is low. Every other output parks low.

A diagnostic combination is entered when the test level is mid and the synchronized stop is high. In that combination the global stop is replaced by a per-bank disable: a bank whose code is low/low is parked, and every other bank keeps running.

Three-level inputs are encoded on two bits: 2'b00 low, 2'b01 mid, and 2'b10 or 2'b11 high. A bank code holds two such digits, {upper, lower}, in four bits. Bank b's code sits at bank_code[4*b+3:4*b], and its outputs are clk_out[2*b+1:2*b]. Banks are numbered 0 to 3 in the RTL. Bank index 1 is the exempt feedback bank, and bank index 3 is the one that can invert.

Top module: `clk_oe_gate`

## Requirements
- R1: Outside the diagnostic combination, while the synchronized stop is high, the outputs of banks 0, 2 and 3 sit constantly at their parked level.
- R2: Outside the diagnostic combination, bank 1 outputs keep following their sources whatever the stop level.
- R3: Bank 3 with code high/high (lower bits of each digit irrelevant beyond bit 1 set) parks high when edge_lvl is mid or high and parks low when edge_lvl is 2'b00; all other banks and codes park low.
- R4: With test_lvl mid (2'b01) and the synchronized stop high, a bank whose code is 4'b0000 is parked and every other bank follows its sources.
- R5: stop_req passes through two flops before use: after stop_req changes, the outputs are unaffected at the first two rising edges.
- R6: A bank stops only when its source is at the parked level, so every non-parked pulse at an output lasts exactly as long as the corresponding source pulse.
- R7: A bank restarts only when its source is at the parked level, so the first non-parked pulse after a restart is a whole source pulse.
- R8: While a bank runs, each of its outputs equals its source as sampled at the previous rising edge of clk.
- R9: During reset all outputs are at their parked levels and the synchronizer holds the stopped state; outside the diagnostic mode, banks 0, 2 and 3 stay parked for the first two edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; all generated clocks are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Active-high output stop request, asynchronous to clk |
| test_lvl | input | 2 | Three-level test-mode setting |
| edge_lvl | input | 2 | Three-level edge-select setting, which decides the inverted bank's parked level |
| bank_code | input | 16 | Four bank codes, each two three-level digits |
| clk_src | input | 8 | Generated clocks from the phase-skew stage, two per bank |
| clk_out | output | 8 | Gated output clocks, two per bank |

## Verification
The assertions assume a few things about the inputs. clk_src is produced in the clk domain and only changes between rising edges. test_lvl, edge_lvl and bank_code are static while out of reset, since a parked level that changes under a running bank would move the output directly. Reset also lasts at least two cycles. The stimulus respects all of this: it generates every source by counting clk cycles, and it changes the configuration only while reset is held. It toggles stop_req at irregular intervals, so stop and restart requests land at every phase of the sources.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;

    localparam int LVL_W  = 2;
    localparam int CODE_W = 2 * LVL_W;

    // Three-level decode: 00 low, 01 mid, 1x high
    function automatic logic lvl_is_low(input logic [LVL_W-1:0] v);
        return v == 2'b00;
    endfunction

    function automatic logic lvl_is_mid(input logic [LVL_W-1:0] v);
        return v == 2'b01;
    endfunction

    function automatic logic code_is_ll(input logic [CODE_W-1:0] c);
        return lvl_is_low(c[CODE_W-1:LVL_W]) && lvl_is_low(c[LVL_W-1:0]);
    endfunction

    function automatic logic code_is_hh(input logic [CODE_W-1:0] c);
        return c[CODE_W-1] && c[LVL_W-1];
    endfunction

    typedef struct packed {
        logic run;
        logic out;
    } cell_state_t;

endpackage

// File: rtl/clk_oe_sync.sv
module clk_oe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int AGE_W = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic [AGE_W-1:0]  age;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
        if (st_q.age != AGE_W'(STAGES)) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    // Reset into the stopped state
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.chain <= '1;
            st_q.age   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            a_r5_two_flop_delay: assert property (@(posedge clk) disable iff (rst)
                (st_q.age == AGE_W'(2)) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/clk_oe_policy.sv
module clk_oe_policy
    import clk_oe_pkg::*;
#(
    parameter bit IS_FB      = 1'b0,
    parameter bit CAN_INVERT = 1'b0
) (
    input  logic              stop_s,
    input  logic [LVL_W-1:0]  test_lvl,
    input  logic [LVL_W-1:0]  edge_lvl,
    input  logic [CODE_W-1:0] code,
    output logic              want_run,
    output logic              park_lvl
);
    logic diag;
    logic inverted;

    always_comb begin
        diag     = lvl_is_mid(test_lvl) && stop_s;
        inverted = CAN_INVERT && code_is_hh(code);
        if (diag) begin
            want_run = !code_is_ll(code);
        end else begin
            want_run = !stop_s || IS_FB;
        end
        park_lvl = inverted && !lvl_is_low(edge_lvl);
    end

endmodule

// File: rtl/clk_oe_cell.sv
module clk_oe_cell
    import clk_oe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic want_run,
    input  logic park_lvl,
    output logic dout
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Change run state only while the source rests at the parked level
        if ((st_q.run != want_run) && (src == park_lvl)) begin
            st_d.run = want_run;
        end
        st_d.out = st_d.run ? src : park_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.run <= 1'b0;
            st_q.out <= park_lvl;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.out;

    a_r8_out_tracks_src: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> (dout == $past(src)));

    a_r6_stop_at_park: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.run) |-> (dout == park_lvl));

    a_r7_start_at_park: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.run) |-> (dout == park_lvl));

    a_r9_reset_parked: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == park_lvl));

endmodule

// File: rtl/clk_oe_gate.sv
module clk_oe_gate
    import clk_oe_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 2,
    parameter int FB_BANK       = 1,
    parameter int INV_BANK      = 3,
    parameter int SYNC_STAGES   = 2,
    localparam int NUM_OUTS     = NUM_BANKS * OUTS_PER_BANK,
    localparam int CODES_W      = NUM_BANKS * CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stop_req,
    input  logic [LVL_W-1:0]    test_lvl,
    input  logic [LVL_W-1:0]    edge_lvl,
    input  logic [CODES_W-1:0]  bank_code,
    input  logic [NUM_OUTS-1:0] clk_src,
    output logic [NUM_OUTS-1:0] clk_out
);
    logic                 stop_s;
    logic [NUM_BANKS-1:0] want_run;
    logic [NUM_BANKS-1:0] park_lvl;

    clk_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stop_req),
        .dout (stop_s)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            clk_oe_policy #(
                .IS_FB      (b == FB_BANK),
                .CAN_INVERT (b == INV_BANK)
            ) u_pol (
                .stop_s   (stop_s),
                .test_lvl (test_lvl),
                .edge_lvl (edge_lvl),
                .code     (bank_code[b*CODE_W +: CODE_W]),
                .want_run (want_run[b]),
                .park_lvl (park_lvl[b])
            );

            for (genvar k = 0; k < OUTS_PER_BANK; k++) begin : g_out
                clk_oe_cell u_cell (
                    .clk      (clk),
                    .rst      (rst),
                    .src      (clk_src[b*OUTS_PER_BANK + k]),
                    .want_run (want_run[b]),
                    .park_lvl (park_lvl[b]),
                    .dout     (clk_out[b*OUTS_PER_BANK + k])
                );
            end

            if (b != FB_BANK) begin : g_stoppable
                a_r1_bank_stops: assert property (@(posedge clk) disable iff (rst)
                    (stop_s && !lvl_is_mid(test_lvl)) |-> !want_run[b]);
            end

            a_r4_ll_disabled: assert property (@(posedge clk) disable iff (rst)
                (stop_s && lvl_is_mid(test_lvl) && code_is_ll(bank_code[b*CODE_W +: CODE_W]))
                |-> !want_run[b]);

            a_r4_others_run: assert property (@(posedge clk) disable iff (rst)
                (stop_s && lvl_is_mid(test_lvl) && !code_is_ll(bank_code[b*CODE_W +: CODE_W]))
                |-> want_run[b]);
        end
    endgenerate

    a_r2_feedback_kept: assert property (@(posedge clk) disable iff (rst)
        !lvl_is_mid(test_lvl) |-> want_run[FB_BANK]);

endmodule

// File: tb/test_clk_oe_gate.sv
module test_clk_oe_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_req = 1'b0;
    logic [1:0]  test_lvl = 2'b00;
    logic [1:0]  edge_lvl = 2'b00;
    logic [3:0]  cfg_code = 4'b0000;
    logic [15:0] bank_code;
    logic [7:0]  clk_src = '0;
    logic [7:0]  clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    assign bank_code = {4{cfg_code}};

    always #5 clk = ~clk;

    clk_oe_gate i_clk_oe_gate (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_req),
        .test_lvl  (test_lvl),
        .edge_lvl  (edge_lvl),
        .bank_code (bank_code),
        .clk_src   (clk_src),
        .clk_out   (clk_out)
    );

    function automatic int half_of(input int i);
        return 1 + (i % 3);
    endfunction

    function automatic logic [1:0] lv(input int n);
        return (n == 0) ? 2'b00 : ((n == 1) ? 2'b01 : 2'b10);
    endfunction

    function automatic logic exp_run(input int b, input logic stp);
        if (test_lvl == 2'b01 && stp) return cfg_code != 4'b0000;
        return !stp || (b == 1);
    endfunction

    function automatic logic exp_park(input int b);
        return (b == 3) && cfg_code[3] && cfg_code[1] && (edge_lvl != 2'b00);
    endfunction

    function automatic string tag_for(input int b, input logic stp);
        if (test_lvl == 2'b01 && stp) return "R4";
        if (stp && b == 1) return "R2";
        if (stp && b == 3 && cfg_code[3] && cfg_code[1]) return "R3";
        if (stp) return "R1";
        return "R8";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic smp;
        @(posedge clk);
        #2;
    endtask

    // Source clocks: counter-derived, updated on falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < 8; i++) clk_src[i] = ((cyc + i) / half_of(i)) % 2;
        end
    end

    // Pulse-width monitor for R6 and R7
    int run_len [8];
    initial begin
        for (int i = 0; i < 8; i++) run_len[i] = 0;
        forever begin
            @(posedge clk);
            #3;
            for (int i = 0; i < 8; i++) begin
                if (rst) begin
                    run_len[i] = 0;
                end else if (clk_out[i] != exp_park(i / 2)) begin
                    run_len[i]++;
                end else if (run_len[i] > 0) begin
                    chk(run_len[i] == half_of(i), "R6,R7 pulse width",
                        8'(run_len[i]), 8'(half_of(i)));
                    run_len[i] = 0;
                end
            end
        end
    end

    task automatic check_banks(input logic stp);
        for (int b = 0; b < 4; b++) begin
            logic [1:0] e;
            e = exp_run(b, stp) ? clk_src[2*b +: 2] : {2{exp_park(b)}};
            chk(clk_out[2*b +: 2] == e, tag_for(b, stp), {6'b0, clk_out[2*b +: 2]}, {6'b0, e});
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int t = 0; t < 3; t++) begin
            for (int e = 0; e < 3; e++) begin
                for (int c = 0; c < 9; c++) begin
                    for (int sv = 0; sv < 2; sv++) begin
                        @(negedge clk);
                        rst      = 1'b1;
                        test_lvl = lv(t);
                        edge_lvl = lv(e);
                        cfg_code = {lv(c / 3), lv(c % 3)};
                        stop_req = sv[0];
                        repeat (2) smp;
                        // R9: parked during reset
                        for (int b = 0; b < 4; b++)
                            chk(clk_out[2*b +: 2] == {2{exp_park(b)}}, "R9 reset",
                                {6'b0, clk_out[2*b +: 2]}, {6'b0, {2{exp_park(b)}}});
                        @(negedge clk);
                        rst = 1'b0;
                        for (int s = 0; s < 2; s++) begin
                            smp;
                            if (t != 1) begin
                                for (int b = 0; b < 4; b++)
                                    if (b != 1)
                                        chk(clk_out[2*b +: 2] == {2{exp_park(b)}}, "R5 R9 post-reset",
                                            {6'b0, clk_out[2*b +: 2]}, {6'b0, {2{exp_park(b)}}});
                            end
                        end
                        repeat (24) smp;
                        for (int s = 0; s < 12; s++) begin
                            smp;
                            check_banks(sv[0]);
                        end
                        if (t != 1 && sv == 0) begin
                            @(negedge clk);
                            stop_req = 1'b1;
                            for (int s = 0; s < 2; s++) begin
                                smp;
                                chk(clk_out[1:0] == clk_src[1:0], "R5 sync delay",
                                    {6'b0, clk_out[1:0]}, {6'b0, clk_src[1:0]});
                            end
                            repeat (20) smp;
                            for (int s = 0; s < 4; s++) begin
                                smp;
                                check_banks(1'b1);
                            end
                            @(negedge clk);
                            stop_req = 1'b0;
                            repeat (20) smp;
                            for (int s = 0; s < 4; s++) begin
                                smp;
                                check_banks(1'b0);
                            end
                        end
                        // Irregular stop toggling; the monitor checks R6 and R7
                        for (int k = 0; k < 6; k++) begin
                            @(negedge clk);
                            stop_req = ~stop_req;
                            repeat (2 + k) @(negedge clk);
                        end
                        @(negedge clk);
                        stop_req = 1'b0;
                        repeat (12) smp;
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule